// File: doc/BRIEF.md
# Compact Timer with Compare Output

An up-counting timer with a single output pin and two comparators. The period comparator holds only the top few bits of the count, so periods come in coarse, equal steps. The second comparator, A, holds a full-width value and acts on the pin. Three modes share the counter:
- compare-match output, where an A match sets, clears or toggles the pin;
- PWM output, where the pin is active from counter zero up to the A value;
- plain timer/counter, where the pin is left alone.

Both comparators raise one-cycle match flags in every mode. A select bit picks which comparator clears the counter. A polarity bit inverts the final pin level. Each low-to-high change of the enable bit restarts counting from zero and returns the pin to a programmable initial level.

The counter width `CNT_W` (default 10) and the period field width `PER_W` (default 3) are parameters. One period step is STEP = 2^(CNT_W-PER_W) clocks, which is 128 clocks by default.

Top module: `ctm_timer`

## Requirements
- R1: After reset, `pin_o` equals `pol_i` (internal level 0) and both `p_flag_o` and `a_flag_o` are low.
- R2: While `on_i` is low the counter is held at zero and both flags stay low. After `on_i` rises, counting starts, and the first P flag appears exactly N clock edges after the first edge that samples `on_i` high.
- R3: With `clr_sel_i`=0 and period code n in 1..2^PER_W-1, the counter runs 0..n*STEP-1 and then returns to zero. `p_flag_o` is high for one cycle after the edge that performs that return, so it recurs every N = n*STEP clocks.
- R4: Period code 0 gives a full wrap, N = 2^CNT_W clocks.
- R5: With `clr_sel_i`=1, an A match clears the counter, so the period is `cmpa_i`+1 clocks. `p_flag_o` still pulses one edge after the count reaches the period end value, but it no longer clears the counter.
- R6: `a_flag_o` is high for one cycle after each edge at which the counter equalled `cmpa_i` while `on_i` was high.
- R7: In compare mode (`mode_i`=00), an A match acts on the pin level at the same edge that raises `a_flag_o`. The `pinfn_i` codes are: 00 no change, 01 drive low, 10 drive high, 11 toggle. Requesting the level already present leaves the pin unchanged.
- R8: The first edge that samples `on_i` high loads the pin level from `init_lvl_i`. This has priority over an A match seen in the same cycle; the A flag is still raised.
- R9: In PWM mode (`mode_i`=10) with `pinfn_i`=10, the pin level is 1 while the counter is below `cmpa_i` and 0 otherwise. A value of 0 gives a constant 0, and a value of N or more gives a constant 1.
- R10: In PWM mode, `pinfn_i`=00 forces level 0 and 01 forces level 1, from the second edge after `on_i` rises onward. `pinfn_i`=11 holds the level.
- R11: `pin_o` is always the internal level XOR `pol_i`.
- R12: In timer mode (`mode_i`=11) and with the reserved mode code 01, `pin_o` holds the initial level whatever `pinfn_i` is, while both flags keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| on_i | input | 1 | Timer enable; rising edge restarts count and pin |
| mode_i | input | 2 | 00 compare, 01 reserved, 10 PWM, 11 timer |
| pinfn_i | input | 2 | Pin action code, meaning per mode |
| init_lvl_i | input | 1 | Pin level loaded on enable rising edge |
| pol_i | input | 1 | Output inversion |
| clr_sel_i | input | 1 | 0: P match clears counter, 1: A match clears counter |
| per_i | input | PER_W | Period code compared with counter top bits |
| cmpa_i | input | CNT_W | Compare A value |
| pin_o | output | 1 | Output pin |
| p_flag_o | output | 1 | One-cycle P match flag |
| a_flag_o | output | 1 | One-cycle A match flag |

## Verification
The bench builds the timer with CNT_W=6 and PER_W=3, so one period step is 8 clocks and a full wrap takes 64. With these values every period code, the full-wrap case of code 0, A values beyond the period and repeated compare toggles all fit in runs of a few dozen cycles. The bench models count, flags and pin level cycle by cycle from the requirements. It checks each mode over at least two periods.

// File: rtl/ctm_pkg.sv
`timescale 1ns/1ps
package ctm_pkg;

  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_RSV = 2'b01,
    MODE_PWM = 2'b10,
    MODE_TMR = 2'b11
  } ctm_mode_e;

  // compare-mode pin actions
  localparam logic [1:0] FN_KEEP   = 2'b00;
  localparam logic [1:0] FN_LOW    = 2'b01;
  localparam logic [1:0] FN_HIGH   = 2'b10;
  localparam logic [1:0] FN_TOGGLE = 2'b11;

  // PWM-mode pin actions
  localparam logic [1:0] FN_PWM_OFF = 2'b00;
  localparam logic [1:0] FN_PWM_ON  = 2'b01;
  localparam logic [1:0] FN_PWM_RUN = 2'b10;

endpackage

// File: rtl/ctm_rst_sync.sv
`timescale 1ns/1ps
module ctm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ctm_counter.sv
`timescale 1ns/1ps
module ctm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!run_i)     cnt_d = '0;
    else if (clr_i) cnt_d = '0;
    else            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ctm_match.sv
`timescale 1ns/1ps
module ctm_match #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic             p_hit_o,
  output logic             a_hit_o
);

  localparam int LOW_W = CNT_W - PER_W;

  logic [CNT_W-1:0] cnt_inc;
  logic             low_zero;
  logic             top_eq;

  // P matches on the last count of the period: the next value would
  // carry the period code in its top bits with zero below.
  assign cnt_inc = cnt_i + CNT_W'(1);
  assign top_eq  = (cnt_inc[CNT_W-1 -: PER_W] == per_i);

  generate
    if (LOW_W > 0) begin : g_low
      assign low_zero = (cnt_inc[LOW_W-1:0] == '0);
    end else begin : g_nolow
      assign low_zero = 1'b1;
    end
  endgenerate

  assign p_hit_o = run_i && top_eq && low_zero;
  assign a_hit_o = run_i && (cnt_i == cmpa_i);

endmodule

// File: rtl/ctm_pin.sv
`timescale 1ns/1ps
module ctm_pin
  import ctm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       pinfn_i,
  input  logic             init_lvl_i,
  input  logic             pol_i,
  input  logic             a_hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic             pin_o
);

  logic      lvl_q;
  logic      lvl_d;
  logic      lvl_en;
  logic      pwm_run;
  logic      pwm_act;
  ctm_mode_e mode;

  assign mode = ctm_mode_e'(mode_i);

  always_comb begin
    lvl_en = 1'b0;
    lvl_d  = lvl_q;
    if (rise_i) begin
      lvl_en = 1'b1;
      lvl_d  = init_lvl_i;
    end else if (run_i) begin
      unique case (mode)
        MODE_CMP: begin
          if (a_hit_i) begin
            unique case (pinfn_i)
              FN_LOW:    begin lvl_en = 1'b1; lvl_d = 1'b0;   end
              FN_HIGH:   begin lvl_en = 1'b1; lvl_d = 1'b1;   end
              FN_TOGGLE: begin lvl_en = 1'b1; lvl_d = ~lvl_q; end
              default:   ;
            endcase
          end
        end
        MODE_PWM: begin
          unique case (pinfn_i)
            FN_PWM_OFF: begin lvl_en = 1'b1; lvl_d = 1'b0; end
            FN_PWM_ON:  begin lvl_en = 1'b1; lvl_d = 1'b1; end
            default:    ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      lvl_q <= 1'b0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign pwm_run = run_i && (mode == MODE_PWM) && (pinfn_i == FN_PWM_RUN);
  assign pwm_act = (cnt_i < cmpa_i);
  assign pin_o   = (pwm_run ? pwm_act : lvl_q) ^ pol_i;

endmodule

// File: rtl/ctm_timer.sv
`timescale 1ns/1ps
module ctm_timer #(
  parameter int CNT_W       = 10,
  parameter int PER_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       pinfn_i,
  input  logic             init_lvl_i,
  input  logic             pol_i,
  input  logic             clr_sel_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmpa_i,
  output logic             pin_o,
  output logic             p_flag_o,
  output logic             a_flag_o
);

  logic             rst_n;
  logic             on_q;
  logic             rise;
  logic             p_hit;
  logic             a_hit;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  logic             p_flag_q;
  logic             a_flag_q;

  ctm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_i;
  end

  assign rise    = on_i && !on_q;
  assign cnt_clr = clr_sel_i ? a_hit : p_hit;

  ctm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .run_i (on_i),
    .clr_i (cnt_clr),
    .cnt_o (cnt_q)
  );

  ctm_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
    .run_i   (on_i),
    .cnt_i   (cnt_q),
    .per_i   (per_i),
    .cmpa_i  (cmpa_i),
    .p_hit_o (p_hit),
    .a_hit_o (a_hit)
  );

  ctm_pin #(.CNT_W(CNT_W)) u_pin (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .run_i      (on_i),
    .rise_i     (rise),
    .mode_i     (mode_i),
    .pinfn_i    (pinfn_i),
    .init_lvl_i (init_lvl_i),
    .pol_i      (pol_i),
    .a_hit_i    (a_hit),
    .cnt_i      (cnt_q),
    .cmpa_i     (cmpa_i),
    .pin_o      (pin_o)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      p_flag_q <= 1'b0;
      a_flag_q <= 1'b0;
    end else begin
      p_flag_q <= p_hit;
      a_flag_q <= a_hit;
    end
  end

  assign p_flag_o = p_flag_q;
  assign a_flag_o = a_flag_q;

endmodule

// File: rtl/ctm_timer_chk.sv
`timescale 1ns/1ps
module ctm_timer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             on_i,
  input logic [1:0]       mode_i,
  input logic             init_lvl_i,
  input logic             pol_i,
  input logic             clr_sel_i,
  input logic [CNT_W-1:0] cmpa_i,
  input logic             pin_o,
  input logic             p_flag_o,
  input logic             a_flag_o,
  input logic [CNT_W-1:0] cnt_q
);

  // R2: counter sits at zero after a cycle with enable low
  p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !on_i |=> (cnt_q == '0));

  // R3: while enabled the count either advances by one or returns to zero
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    on_i |=> ((cnt_q == '0) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

  // R3: a P flag with P-clear selected coincides with a zero count
  p_pclear_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (p_flag_o && !$past(clr_sel_i)) |-> (cnt_q == '0));

  // R6: an A flag follows a cycle where count equalled the A value
  p_aflag_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    a_flag_o |-> ($past(cnt_q) == $past(cmpa_i)));

  // R8: enable rising in compare mode loads the initial level
  p_rise_init_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(on_i) && (mode_i == 2'b00)) |=> (pin_o == ($past(init_lvl_i) ^ pol_i)));

  // R12: timer mode leaves the pin untouched once running
  p_timer_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((mode_i == 2'b11) && ($past(mode_i) == 2'b11) && on_i && $past(on_i)
     && $past(on_i, 2) && $stable(pol_i)) |-> $stable(pin_o));

endmodule

bind ctm_timer ctm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .on_i       (on_i),
  .mode_i     (mode_i),
  .init_lvl_i (init_lvl_i),
  .pol_i      (pol_i),
  .clr_sel_i  (clr_sel_i),
  .cmpa_i     (cmpa_i),
  .pin_o      (pin_o),
  .p_flag_o   (p_flag_o),
  .a_flag_o   (a_flag_o),
  .cnt_q      (cnt_q)
);

// File: tb/sim_ctm_timer.sv
`timescale 1ns/1ps
module sim_ctm_timer;

  localparam int CW   = 6;
  localparam int PW   = 3;
  localparam int STEP = 1 << (CW - PW);
  localparam int FULL = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          on_i;
  logic [1:0]    mode_i;
  logic [1:0]    pinfn_i;
  logic          init_lvl_i;
  logic          pol_i;
  logic          clr_sel_i;
  logic [PW-1:0] per_i;
  logic [CW-1:0] cmpa_i;
  logic          pin_o;
  logic          p_flag_o;
  logic          a_flag_o;

  always #2.5 clk = ~clk;

  ctm_timer #(.CNT_W(CW), .PER_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .on_i(on_i), .mode_i(mode_i),
    .pinfn_i(pinfn_i), .init_lvl_i(init_lvl_i), .pol_i(pol_i),
    .clr_sel_i(clr_sel_i), .per_i(per_i), .cmpa_i(cmpa_i),
    .pin_o(pin_o), .p_flag_o(p_flag_o), .a_flag_o(a_flag_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    chk_pin;
    logic  pin;
    logic  pf;
    logic  af;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // model configuration of the current run
  int m_mode, m_fn, m_init, m_pol, m_clr, m_per, m_cmpa;

  function automatic int cnt_at(int k);
    int m;
    if (m_clr == 0) m = (m_per == 0) ? FULL : m_per * STEP;
    else            m = m_cmpa + 1;
    return k % m;
  endfunction

  function automatic bit pf_at(int k);
    int pend;
    pend = (m_per == 0) ? FULL - 1 : m_per * STEP - 1;
    return (k >= 1) && (cnt_at(k - 1) == pend);
  endfunction

  function automatic bit af_at(int k);
    return (k >= 1) && (cnt_at(k - 1) == m_cmpa);
  endfunction

  task automatic check1(string tag, string name, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, name, cyc, act, exp);
    end
  endtask

  // monitor: pops expectations when their cycle arrives
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        if (e.at < cyc) begin
          n_run++;
          n_fail++;
          $display("FAIL %s stale item: actual cycle=%0d expected cycle=%0d", e.tag, cyc, e.at);
        end else begin
          if (e.chk_pin) check1(e.tag, "pin_o", pin_o, e.pin);
          check1(e.tag, "p_flag_o", p_flag_o, e.pf);
          check1(e.tag, "a_flag_o", a_flag_o, e.af);
        end
      end
    end
  end

  task automatic push(int at, bit chk_pin, logic pin, logic pf, logic af, string tag);
    exp_t e;
    e.at = at; e.chk_pin = chk_pin; e.pin = pin; e.pf = pf; e.af = af; e.tag = tag;
    sbq.push_back(e);
  endtask

  // driver: one cycle off with new settings, then enable; returns cycle index
  task automatic start_run(int mode, int fn, int init, int pol, int clr,
                           int per, int cmpa, output int c);
    @(negedge clk);
    on_i = 1'b0;
    mode_i = 2'(mode); pinfn_i = 2'(fn); init_lvl_i = 1'(init);
    pol_i = 1'(pol); clr_sel_i = 1'(clr); per_i = PW'(per); cmpa_i = CW'(cmpa);
    m_mode = mode; m_fn = fn; m_init = init; m_pol = pol;
    m_clr = clr; m_per = per; m_cmpa = cmpa;
    @(negedge clk);
    on_i = 1'b1;
    c = cyc;
  endtask

  task automatic expect_run(int c, int len, string tag);
    logic lvl;
    logic pin;
    lvl = 1'b0;
    for (int k = 1; k <= len; k++) begin
      if (k == 1) lvl = 1'(m_init);
      if (m_mode == 0) begin
        if (k >= 2 && af_at(k)) begin
          case (m_fn)
            1: lvl = 1'b0;
            2: lvl = 1'b1;
            3: lvl = ~lvl;
            default: ;
          endcase
        end
        pin = lvl ^ 1'(m_pol);
      end else if (m_mode == 2 && m_fn == 2) begin
        pin = 1'(cnt_at(k) < m_cmpa) ^ 1'(m_pol);
      end else if (m_mode == 2 && m_fn < 2) begin
        if (k >= 2) lvl = 1'(m_fn);
        pin = lvl ^ 1'(m_pol);
      end else begin
        pin = lvl ^ 1'(m_pol);
      end
      push(c + k, 1'b1, pin, pf_at(k), af_at(k), tag);
    end
    repeat (len) @(negedge clk);
  endtask

  task automatic run(int mode, int fn, int init, int pol, int clr,
                     int per, int cmpa, int len, string tag);
    int c;
    start_run(mode, fn, init, pol, clr, per, cmpa, c);
    expect_run(c, len, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    rst_ni = 1'b0; on_i = 1'b0; mode_i = 2'b00; pinfn_i = 2'b00;
    init_lvl_i = 1'b0; pol_i = 1'b0; clr_sel_i = 1'b0;
    per_i = '0; cmpa_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    push(cyc + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    push(cyc + 2, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    repeat (2) @(negedge clk);

    // R3 R6 R12: timer mode, period code 3 (24 clocks), toggle code ignored
    run(3, 3, 1, 0, 0, 3, 3, 56, "R3/R12");

    // R2: enable low holds count, flags stay low
    @(negedge clk);
    on_i = 1'b0;
    c = cyc;
    for (int k = 1; k <= 20; k++) push(c + k, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    repeat (20) @(negedge clk);

    // R2: restart counts from zero, first P flag after N edges
    run(3, 0, 0, 0, 0, 2, 40, 40, "R2");

    // R4: period code 0 wraps at full count
    run(3, 0, 0, 0, 0, 0, 10, 140, "R4");

    // R5: A match clears, P flag still pulses without clearing
    run(3, 0, 0, 0, 1, 1, 9, 45, "R5");

    // R7 R6: compare mode drive high, then low, then toggle
    run(0, 2, 0, 0, 0, 2, 5, 36, "R7");
    run(0, 1, 1, 0, 0, 2, 5, 36, "R7");
    run(0, 3, 0, 0, 0, 2, 5, 52, "R7");
    // R7: no-change code and a request equal to the current level
    run(0, 0, 1, 0, 0, 2, 5, 36, "R7");
    run(0, 2, 1, 0, 0, 2, 5, 36, "R7");

    // R8: restart returns pin to initial level; priority over A match at zero
    run(0, 2, 0, 0, 0, 1, 0, 24, "R8");

    // R9: PWM run, normal, zero and beyond-period compare values
    run(2, 2, 0, 0, 0, 2, 5, 40, "R9");
    run(2, 2, 0, 0, 0, 2, 0, 20, "R9");
    run(2, 2, 0, 0, 0, 2, 20, 20, "R9");

    // R10: PWM forced levels
    run(2, 1, 0, 0, 0, 2, 5, 20, "R10");
    run(2, 0, 1, 0, 0, 2, 5, 20, "R10");
    run(2, 3, 1, 0, 0, 2, 5, 20, "R10");

    // R11: polarity on PWM and compare outputs
    run(2, 2, 0, 1, 0, 2, 5, 36, "R11");
    run(0, 2, 0, 1, 0, 2, 5, 24, "R11");

    // R12: reserved mode code holds pin
    run(1, 2, 1, 0, 0, 1, 3, 20, "R12");

    @(negedge clk);
    on_i = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule